// File: doc/BRIEF.md
# Range Translation Buffer with Pinned Slots

This block is a small fully associative address translation buffer. Each slot holds an inclusive virtual window, a physical base and a 10-bit attribute word. A lookup port compares the incoming virtual address against every slot in the same cycle. It returns the translated physical address and the attributes of the matching slot, or it reports a miss. Windows are a power-of-four multiple of a 4 KiB page. This allows one slot to map anything from a single page up to a very large region.

A command port with a valid/ready handshake maintains the contents. The commands are: a one-step insert, a two-step insert (address step, then attribute step), a range purge, a purge of every ordinary slot, and a slot-indexed insert and purge for a low group of pinned slots. Ordinary purges never remove the pinned slots. Every command finishes in the cycle it is accepted and returns a status code one cycle later. New ordinary entries go into the lowest free slot. When no ordinary slot is free, a round-robin victim pointer picks the slot.

Top module: `range_tlb`

## Requirements
- R1: The lookup is combinational. lkHit is 1 when some valid slot has start ≤ lkAddr ≤ last. lkPa is then that slot's physical base plus (lkAddr − start), and lkAttr is its attributes. When several slots match, the lowest-numbered slot wins. On a miss, lkHit, lkPa and lkAttr are all 0.
- R2: A one-step insert (cmdOp 0) takes n from cmdSize and builds a window of 4096·4^n bytes. The window starts at cmdAddr aligned down to that size. The physical base is cmdPa aligned down to the same size. The new entry is valid with attributes cmdAttr.
- R3: Before any insert (one-step, address step or pinned) writes a slot, every valid ordinary slot whose window overlaps the new window is invalidated in the same cycle.
- R4: An ordinary slot for a new entry is the lowest-numbered ordinary slot that is free. Slots freed by the overlap purge of the same command count as free.
- R5: When no ordinary slot is free, the victim is the round-robin pointer. The pointer resets to PINNED. If it lies below PINNED or at or beyond ENTRIES, it is first moved to PINNED. After each such use it advances by one.
- R6: A range purge (cmdOp 3) reads n from cmdAddr[3:0]. It invalidates every valid ordinary slot that overlaps the window starting at the page-aligned cmdAddr and spanning 4096·4^n bytes. Pinned slots are not affected.
- R7: A purge-all (cmdOp 4) invalidates every ordinary slot, resets the round-robin pointer to PINNED and drops any pending two-step entry. Pinned slots keep their contents.
- R8: An address step (cmdOp 1) writes a one-page window and a physical page into a slot that stays invalid. An attribute step (cmdOp 2) whose cmdAddr falls inside that pending window makes it valid with cmdAttr and returns code 0. Any other attribute step drops the pending entry, leaves the slot invalid and returns code −1.
- R9: A pinned insert (cmdOp 5) with cmdSlot < PINNED overwrites that slot with a window built as in R2. Attribute bit 8 (dirty) is forced to 1 and bit 9 (trap) to 0. A pinned purge (cmdOp 6) with cmdSlot < PINNED invalidates that slot.
- R10: A pinned insert or pinned purge with cmdSlot ≥ PINNED returns code −10 and changes nothing.
- R11: cmdReady is always 1. The cycle after a command is accepted, rspValid is 1 and rspCode holds the status (0, −1 or −10 in two's complement), and lookups already see the new contents. cmdOp 7 does nothing and returns 0. rspValid is 0 in any cycle that does not follow an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be accepted (always 1) |
| cmdOp | input | 3 | Command code |
| cmdAddr | input | VA_W | Virtual address; low 4 bits hold the size code for range purge |
| cmdPa | input | PA_W | Physical base |
| cmdSize | input | 4 | Size code n for inserts |
| cmdAttr | input | 10 | Attribute word |
| cmdSlot | input | log2(ENTRIES) | Pinned slot index |
| rspValid | output | 1 | Status valid |
| rspCode | output | 8 | Signed status code |
| lkAddr | input | VA_W | Lookup virtual address |
| lkHit | output | 1 | Lookup hit |
| lkPa | output | PA_W | Translated physical address |
| lkAttr | output | 10 | Attributes of the hit slot |

## Verification
Overlap purging and slot allocation can both happen in the same cycle. The bench fills every ordinary slot, advances the round-robin pointer, and then inserts a 16 KiB window that covers four existing pages. The new entry must take the lowest slot that the purge has just freed, not the slot the round-robin pointer names. The next insert must take another freed slot and leave the slot named by the pointer untouched. The bench judges this only through lookups: it checks which old pages still hit and which now miss, and where the new windows translate.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

  typedef enum logic [2:0] {
    OP_INSERT    = 3'd0,
    OP_ADDR      = 3'd1,
    OP_PROT      = 3'd2,
    OP_PURGE     = 3'd3,
    OP_PURGE_ALL = 3'd4,
    OP_PIN_INS   = 3'd5,
    OP_PIN_PURGE = 3'd6,
    OP_NOP       = 3'd7
  } op_e;

  // attribute word: trap[9] dirty[8] brk[7] kind[6:4] plHi[3:2] plLo[1:0]
  typedef struct packed {
    logic       trap;
    logic       dirty;
    logic       brk;
    logic [2:0] kind;
    logic [1:0] plHi;
    logic [1:0] plLo;
  } attr_t;

  typedef struct packed {
    logic purgeOvl;
    logic purgeAll;
    logic purgeSlot;
    logic writeFull;
    logic writeAddr;
    logic writeProt;
  } strobe_t;

  localparam logic [7:0] CODE_OK      = 8'h00;
  localparam logic [7:0] CODE_ORPHAN  = 8'hFF;  // -1
  localparam logic [7:0] CODE_BADSLOT = 8'hF6;  // -10

endpackage

// File: rtl/range_tlb_ctrl.sv
module range_tlb_ctrl
  import range_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ENTRIES   = 8,
  parameter int PINNED    = 2,
  parameter int PAGE_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  output logic                       cmdReady,
  input  logic [2:0]                 cmdOp,
  input  logic [VA_W-1:0]            cmdAddr,
  input  logic [PA_W-1:0]            cmdPa,
  input  logic [3:0]                 cmdSize,
  input  attr_t                      cmdAttr,
  input  logic [$clog2(ENTRIES)-1:0] cmdSlot,
  input  logic [ENTRIES-1:0]         validVec,
  input  logic [ENTRIES-1:0]         ovlVec,
  output logic                       rspValid,
  output logic [7:0]                 rspCode,
  output strobe_t                    stb,
  output logic [$clog2(ENTRIES)-1:0] wrIdx,
  output logic [VA_W-1:0]            qStart,
  output logic [VA_W-1:0]            qLast,
  output logic [PA_W-1:0]            wrPa,
  output attr_t                      wrAttr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PTR_W = $clog2(ENTRIES + 1);
  localparam logic [63:0] VA_MAX    = (64'd1 << VA_W) - 64'd1;
  localparam logic [63:0] PAGE_MASK = (64'd1 << PAGE_BITS) - 64'd1;

  op_e op;
  logic accept;
  assign op       = op_e'(cmdOp);
  assign cmdReady = 1'b1;
  assign accept   = cmdValid;

  // window arithmetic
  logic [3:0]  nSel;
  int          shAmt;
  logic [63:0] span64, lo64, hi64;

  always_comb begin
    case (op)
      OP_PURGE: nSel = cmdAddr[3:0];
      OP_ADDR:  nSel = 4'd0;
      default:  nSel = cmdSize;
    endcase
    shAmt  = PAGE_BITS + 2 * int'(nSel);
    span64 = (64'd1 << shAmt) - 64'd1;
    if (op == OP_PURGE) begin
      lo64 = 64'(cmdAddr) & ~PAGE_MASK;
      hi64 = lo64 + span64;
    end else begin
      lo64 = 64'(cmdAddr) & ~span64;
      hi64 = lo64 | span64;
    end
    qStart = lo64[VA_W-1:0];
    qLast  = (hi64 > VA_MAX) ? '1 : hi64[VA_W-1:0];
    wrPa   = cmdPa & ~span64[PA_W-1:0];
  end

  // pending two-step entry and round-robin pointer
  logic             pendBusy;
  logic [IDX_W-1:0] pendIdx;
  logic [VA_W-1:0]  pendLo, pendHi;
  logic [PTR_W-1:0] rrPtr, rrBase;
  logic             inPend, slotOk;

  assign inPend = (cmdAddr >= pendLo) && (cmdAddr <= pendHi);
  assign slotOk = int'(cmdSlot) < PINNED;
  assign rrBase = (int'(rrPtr) < PINNED || int'(rrPtr) >= ENTRIES) ? PTR_W'(PINNED) : rrPtr;

  // allocation: lowest free ordinary slot, counting slots freed this cycle
  logic [ENTRIES-1:0] freeAfter;
  logic               haveFree;
  logic [IDX_W-1:0]   freeIdx, allocIdx;

  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      freeAfter[i] = (i >= PINNED) &&
                     ((!validVec[i] && !(pendBusy && pendIdx == IDX_W'(i))) || ovlVec[i]);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (freeAfter[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
    allocIdx = haveFree ? freeIdx : rrBase[IDX_W-1:0];
  end

  // command decode
  logic       allocNow, pendSet, pendClr;
  logic [7:0] code;

  always_comb begin
    stb      = '0;
    wrIdx    = allocIdx;
    wrAttr   = cmdAttr;
    code     = CODE_OK;
    allocNow = 1'b0;
    pendSet  = 1'b0;
    pendClr  = 1'b0;
    if (accept) begin
      case (op)
        OP_INSERT: begin
          stb.purgeOvl  = 1'b1;
          stb.writeFull = 1'b1;
          allocNow      = 1'b1;
          if (pendBusy && !haveFree && allocIdx == pendIdx) pendClr = 1'b1;
        end
        OP_ADDR: begin
          stb.purgeOvl  = 1'b1;
          stb.writeAddr = 1'b1;
          pendSet       = 1'b1;
          if (pendBusy) wrIdx = pendIdx;
          else          allocNow = 1'b1;
        end
        OP_PROT: begin
          pendClr = 1'b1;
          wrIdx   = pendIdx;
          if (pendBusy && inPend) stb.writeProt = 1'b1;
          else                    code = CODE_ORPHAN;
        end
        OP_PURGE: stb.purgeOvl = 1'b1;
        OP_PURGE_ALL: begin
          stb.purgeAll = 1'b1;
          pendClr      = 1'b1;
        end
        OP_PIN_INS: begin
          if (slotOk) begin
            stb.purgeOvl  = 1'b1;
            stb.writeFull = 1'b1;
            wrIdx         = cmdSlot;
            wrAttr.dirty  = 1'b1;
            wrAttr.trap   = 1'b0;
          end else code = CODE_BADSLOT;
        end
        OP_PIN_PURGE: begin
          if (slotOk) begin
            stb.purgeSlot = 1'b1;
            wrIdx         = cmdSlot;
          end else code = CODE_BADSLOT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr    <= PTR_W'(PINNED);
      pendBusy <= 1'b0;
      pendIdx  <= '0;
      pendLo   <= '0;
      pendHi   <= '0;
      rspValid <= 1'b0;
      rspCode  <= CODE_OK;
    end else begin
      rspValid <= accept;
      if (accept) rspCode <= code;
      if (accept && op == OP_PURGE_ALL) rrPtr <= PTR_W'(PINNED);
      else if (allocNow && !haveFree)   rrPtr <= rrBase + PTR_W'(1);
      if (pendSet) begin
        pendBusy <= 1'b1;
        pendIdx  <= wrIdx;
        pendLo   <= qStart;
        pendHi   <= qLast;
      end else if (pendClr) begin
        pendBusy <= 1'b0;
      end
    end
  end

  a_r5_ptr_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rrPtr) >= PINNED) && (int'(rrPtr) <= ENTRIES));

  a_r8_pend_unpinned: assert property (@(posedge clk) disable iff (!rstN)
    pendBusy |-> (int'(pendIdx) >= PINNED));

  a_r10_bad_slot: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (op == OP_PIN_INS || op == OP_PIN_PURGE) && !slotOk)
      |=> (rspValid && rspCode == CODE_BADSLOT));

  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);

  a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);

endmodule

// File: rtl/range_tlb_store.sv
module range_tlb_store
  import range_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 8,
  parameter int PINNED  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [$clog2(ENTRIES)-1:0] wrIdx,
  input  logic [VA_W-1:0]            qStart,
  input  logic [VA_W-1:0]            qLast,
  input  logic [PA_W-1:0]            wrPa,
  input  attr_t                      wrAttr,
  input  logic [VA_W-1:0]            lkAddr,
  output logic [ENTRIES-1:0]         validVec,
  output logic [ENTRIES-1:0]         ovlVec,
  output logic                       lkHit,
  output logic [PA_W-1:0]            lkPa,
  output attr_t                      lkAttr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [ENTRIES-1:0] PIN_MASK = ENTRIES'((64'd1 << PINNED) - 64'd1);

  logic [ENTRIES-1:0] hitVec;
  logic [PA_W-1:0]    transPa [ENTRIES];
  attr_t              slotAttr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    localparam bit PIN = (g < PINNED);
    logic            vBit;
    logic [VA_W-1:0] sReg, lReg;
    logic [PA_W-1:0] pReg;
    attr_t           aReg;
    logic            sel;

    assign sel         = (wrIdx == IDX_W'(g));
    assign validVec[g] = vBit;
    assign ovlVec[g]   = vBit && (sReg <= qLast) && (lReg >= qStart);
    assign hitVec[g]   = vBit && (lkAddr >= sReg) && (lkAddr <= lReg);
    assign transPa[g]  = pReg + PA_W'(lkAddr - sReg);
    assign slotAttr[g] = aReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vBit <= 1'b0;
        sReg <= '0;
        lReg <= '0;
        pReg <= '0;
        aReg <= '0;
      end else begin
        if (!PIN && (stb.purgeAll || (stb.purgeOvl && ovlVec[g]))) vBit <= 1'b0;
        if (stb.purgeSlot && sel) vBit <= 1'b0;
        if (sel && (stb.writeFull || stb.writeAddr)) begin
          vBit <= stb.writeFull;
          sReg <= qStart;
          lReg <= qLast;
          pReg <= wrPa;
          aReg <= stb.writeFull ? wrAttr : '0;
        end
        if (sel && stb.writeProt) begin
          vBit <= 1'b1;
          aReg <= wrAttr;
        end
      end
    end
  end

  // lowest matching slot wins
  always_comb begin
    lkHit  = 1'b0;
    lkPa   = '0;
    lkAttr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        lkHit  = 1'b1;
        lkPa   = transPa[i];
        lkAttr = slotAttr[i];
      end
    end
  end

  a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPa == '0 && lkAttr == '0));

  a_r7_purge_all_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.purgeAll |=> ((validVec & ~PIN_MASK) == '0));

  a_r9_pinned_survive: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.purgeSlot || stb.writeFull) |=> ((validVec & PIN_MASK) == $past(validVec & PIN_MASK)));

  a_r8_prot_on_idle_slot: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeProt |-> !validVec[wrIdx]);

endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ENTRIES   = 8,
  parameter int PINNED    = 2,
  parameter int PAGE_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  output logic                       cmdReady,
  input  logic [2:0]                 cmdOp,
  input  logic [VA_W-1:0]            cmdAddr,
  input  logic [PA_W-1:0]            cmdPa,
  input  logic [3:0]                 cmdSize,
  input  logic [9:0]                 cmdAttr,
  input  logic [$clog2(ENTRIES)-1:0] cmdSlot,
  output logic                       rspValid,
  output logic [7:0]                 rspCode,
  input  logic [VA_W-1:0]            lkAddr,
  output logic                       lkHit,
  output logic [PA_W-1:0]            lkPa,
  output logic [9:0]                 lkAttr
);

  strobe_t                    stb;
  logic [$clog2(ENTRIES)-1:0] wrIdx;
  logic [VA_W-1:0]            qStart, qLast;
  logic [PA_W-1:0]            wrPa;
  attr_t                      wrAttr, hitAttr;
  logic [ENTRIES-1:0]         validVec, ovlVec;

  range_tlb_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES), .PINNED(PINNED), .PAGE_BITS(PAGE_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdPa(cmdPa), .cmdSize(cmdSize),
    .cmdAttr(attr_t'(cmdAttr)), .cmdSlot(cmdSlot),
    .validVec(validVec), .ovlVec(ovlVec),
    .rspValid(rspValid), .rspCode(rspCode), .stb(stb), .wrIdx(wrIdx),
    .qStart(qStart), .qLast(qLast), .wrPa(wrPa), .wrAttr(wrAttr)
  );

  range_tlb_store #(
    .VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES), .PINNED(PINNED)
  ) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx),
    .qStart(qStart), .qLast(qLast), .wrPa(wrPa), .wrAttr(wrAttr),
    .lkAddr(lkAddr), .validVec(validVec), .ovlVec(ovlVec),
    .lkHit(lkHit), .lkPa(lkPa), .lkAttr(hitAttr)
  );

  assign lkAttr = hitAttr;

endmodule

// File: tb/sim_range_tlb.sv
`timescale 1ns/1ps
module sim_range_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = 3'd7;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdPa = '0;
  logic [3:0]  cmdSize = '0;
  logic [9:0]  cmdAttr = '0;
  logic [2:0]  cmdSlot = '0;
  logic        rspValid;
  logic [7:0]  rspCode;
  logic [31:0] lkAddr = '0;
  logic        lkHit;
  logic [31:0] lkPa;
  logic [9:0]  lkAttr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  range_tlb u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdPa(cmdPa), .cmdSize(cmdSize),
    .cmdAttr(cmdAttr), .cmdSlot(cmdSlot), .rspValid(rspValid), .rspCode(rspCode),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkPa(lkPa), .lkAttr(lkAttr)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] addr;
    logic [31:0] pa;
    logic [3:0]  size;
    logic [9:0]  attr;
    logic [2:0]  slot;
    logic [7:0]  code;
    logic [31:0] lk;
    logic        hit;
    logic [31:0] lkPa;
    logic [9:0]  lkAttr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0001_2345, 32'h000A_0000, 4'd0, 10'h005, 3'd0, 8'h00, 32'h0001_2345, 1'b1, 32'h000A_0345, 10'h005}, // R2
    '{3'd0, 32'h0040_0000, 32'h0080_0000, 4'd1, 10'h010, 3'd0, 8'h00, 32'h0040_3ABC, 1'b1, 32'h0080_3ABC, 10'h010}, // R2
    '{3'd0, 32'h0105_6789, 32'h0200_1234, 4'd2, 10'h3FF, 3'd0, 8'h00, 32'h0105_ABCD, 1'b1, 32'h0200_ABCD, 10'h3FF}, // R2
    '{3'd3, 32'h0001_2000, 32'h0,         4'd0, 10'h000, 3'd0, 8'h00, 32'h0001_2345, 1'b0, 32'h0,         10'h000}, // R6
    '{3'd5, 32'h0300_0000, 32'h0700_0000, 4'd0, 10'h2AA, 3'd1, 8'h00, 32'h0300_0010, 1'b1, 32'h0700_0010, 10'h1AA}, // R9
    '{3'd5, 32'h0600_0000, 32'h0,         4'd0, 10'h000, 3'd2, 8'hF6, 32'h0300_0010, 1'b1, 32'h0700_0010, 10'h1AA}, // R10
    '{3'd4, 32'h0,         32'h0,         4'd0, 10'h000, 3'd0, 8'h00, 32'h0300_0010, 1'b1, 32'h0700_0010, 10'h1AA}, // R7
    '{3'd7, 32'h0,         32'h0,         4'd0, 10'h000, 3'd0, 8'h00, 32'h0040_3ABC, 1'b0, 32'h0,         10'h000}, // R7
    '{3'd3, 32'h0300_0000, 32'h0,         4'd0, 10'h000, 3'd0, 8'h00, 32'h0300_0010, 1'b1, 32'h0700_0010, 10'h1AA}, // R6
    '{3'd1, 32'h0500_0000, 32'h0600_0000, 4'd0, 10'h000, 3'd0, 8'h00, 32'h0500_0000, 1'b0, 32'h0,         10'h000}, // R8
    '{3'd2, 32'h0500_0800, 32'h0,         4'd0, 10'h0A3, 3'd0, 8'h00, 32'h0500_0800, 1'b1, 32'h0600_0800, 10'h0A3}, // R8
    '{3'd1, 32'h0510_0000, 32'h0900_0000, 4'd0, 10'h000, 3'd0, 8'h00, 32'h0510_0000, 1'b0, 32'h0,         10'h000}, // R8
    '{3'd2, 32'h0520_0000, 32'h0,         4'd0, 10'h0C1, 3'd0, 8'hFF, 32'h0510_0000, 1'b0, 32'h0,         10'h000}, // R8
    '{3'd6, 32'h0,         32'h0,         4'd0, 10'h000, 3'd1, 8'h00, 32'h0300_0010, 1'b0, 32'h0,         10'h000}, // R9
    '{3'd6, 32'h0,         32'h0,         4'd0, 10'h000, 3'd5, 8'hF6, 32'h0500_0800, 1'b1, 32'h0600_0800, 10'h0A3}  // R10
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] pa,
                       input logic [3:0] size, input logic [9:0] attr, input logic [2:0] slot,
                       input logic [7:0] expCode, input string req);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr; cmdPa = pa;
    cmdSize = size; cmdAttr = attr; cmdSlot = slot;
    check(cmdReady == 1'b1, "R11 ready", 32'(cmdReady), 32'd1);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd7;
    check(rspValid == 1'b1 && rspCode == expCode, req, {23'd0, rspValid, rspCode}, {24'd1, expCode});
  endtask

  task automatic chkLk(input logic [31:0] a, input bit hit, input logic [31:0] pa,
                       input logic [9:0] attr, input string req);
    lkAddr = a;
    #1;
    check(lkHit == hit, req, 32'(lkHit), 32'(hit));
    check(lkPa == pa, req, lkPa, pa);
    check(lkAttr == attr, req, 32'(lkAttr), 32'(attr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R11, R1)
    lkAddr = 32'h0001_2345;
    #1;
    check(rspValid == 1'b0, "R11 reset rspValid", 32'(rspValid), 32'd0);
    check(lkHit == 1'b0 && lkPa == 32'd0 && lkAttr == 10'd0, "R1 reset miss", lkPa, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      doCmd(VECS[v].op, VECS[v].addr, VECS[v].pa, VECS[v].size, VECS[v].attr,
            VECS[v].slot, VECS[v].code, $sformatf("R11 code vec %0d", v));
      chkLk(VECS[v].lk, VECS[v].hit, VECS[v].lkPa, VECS[v].lkAttr, $sformatf("R1 vec %0d", v));
    end
    @(negedge clk);
    check(rspValid == 1'b0, "R11 idle rspValid", 32'(rspValid), 32'd0);

    // R1 priority: pinned slot 0 and an ordinary slot overlap; slot 0 wins (R3 spares pinned)
    doCmd(3'd5, 32'h0800_0000, 32'h1000_0000, 4'd1, 10'h000, 3'd0, 8'h00, "R9 pin slot0");
    doCmd(3'd0, 32'h0800_0000, 32'h2000_0000, 4'd0, 10'h001, 3'd0, 8'h00, "R3 insert under pin");
    chkLk(32'h0800_0100, 1'b1, 32'h1000_0100, 10'h100, "R1 lowest slot wins");

    // R4/R5: fill slots 2..7, then round-robin
    doCmd(3'd4, 32'h0, 32'h0, 4'd0, 10'h0, 3'd0, 8'h00, "R7 purge all");
    for (int k = 0; k < 6; k++)
      doCmd(3'd0, 32'h1000_0000 + 32'(k) * 32'h1000, 32'h4000_0000 + 32'(k) * 32'h1000,
            4'd0, 10'h002, 3'd0, 8'h00, "R4 fill");
    doCmd(3'd0, 32'h1000_6000, 32'h5000_0000, 4'd0, 10'h002, 3'd0, 8'h00, "R5 rr 1");
    chkLk(32'h1000_0000, 1'b0, 32'h0, 10'h0, "R5 victim slot2 gone");
    chkLk(32'h1000_6000, 1'b1, 32'h5000_0000, 10'h002, "R5 new page");
    doCmd(3'd0, 32'h1000_7000, 32'h5000_1000, 4'd0, 10'h002, 3'd0, 8'h00, "R5 rr 2");
    chkLk(32'h1000_1000, 1'b0, 32'h0, 10'h0, "R5 victim slot3 gone");

    // same cycle: overlap purge frees 2,3,6,7; new entry takes slot 2
    doCmd(3'd0, 32'h1000_4000, 32'h6000_0000, 4'd1, 10'h004, 3'd0, 8'h00, "R3 big insert");
    chkLk(32'h1000_5000, 1'b1, 32'h6000_1000, 10'h004, "R3 big window");
    chkLk(32'h1000_7800, 1'b1, 32'h6000_3800, 10'h004, "R3 covered page");
    chkLk(32'h1000_2000, 1'b1, 32'h4000_2000, 10'h002, "R3 untouched page");
    doCmd(3'd0, 32'h1000_9000, 32'h7000_0000, 4'd0, 10'h002, 3'd0, 8'h00, "R4 reuse freed");
    chkLk(32'h1000_2000, 1'b1, 32'h4000_2000, 10'h002, "R4 no rr eviction");
    chkLk(32'h1000_3000, 1'b1, 32'h4000_3000, 10'h002, "R4 no rr eviction 2");
    doCmd(3'd0, 32'h1000_A000, 32'h7000_1000, 4'd0, 10'h002, 3'd0, 8'h00, "R4 fill 6");
    doCmd(3'd0, 32'h1000_B000, 32'h7000_2000, 4'd0, 10'h002, 3'd0, 8'h00, "R4 fill 7");
    doCmd(3'd0, 32'h1000_C000, 32'h7000_3000, 4'd0, 10'h002, 3'd0, 8'h00, "R5 rr 3");
    chkLk(32'h1000_2000, 1'b0, 32'h0, 10'h0, "R5 pointer at slot4");
    chkLk(32'h1000_3000, 1'b1, 32'h4000_3000, 10'h002, "R5 slot5 kept");
    chkLk(32'h1000_C000, 1'b1, 32'h7000_3000, 10'h002, "R5 new page 3");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule